// File: doc/BRIEF.md
# Receive Header-Split Buffer Placement Engine

This block decides where the bytes of one received Ethernet frame land for a single receive descriptor. For each request it takes the frame length, the number of bytes already placed by earlier descriptors, a split point found by an upstream parser, the descriptor layout code, a large-frame enable and a buffer-size control word. From these it issues up to two DMA write commands: one to the header buffer and one to the packet buffer.

Once every issued write has reported completion, the block pulses `done`. Along with that pulse it presents the descriptor writeback fields, the end-of-packet status, the offset the next descriptor must start from, and a pop strobe for the receive FIFO. A frame longer than one packet buffer is spread over several descriptors. Each later request passes the returned offset back in, and the block then fills only the packet buffer.

Top module: `rxhs_place`

## Requirements
- R1: `desc_type` selects the layout: 3'b000 plain, 3'b001 single buffer, 3'b101 header split. Any other code, or a nonzero `start_off` in plain or single-buffer layout, raises `err` for one cycle, issues no command and leaves `busy` low.
- R2: In plain and single-buffer layouts, one packet-buffer command is issued at offset 0 for the whole frame. The writeback has header length 0, split flag 0 and packet length equal to the frame length.
- R3: The packet buffer holds `buf_ctl[7:0]` × 1024 bytes when `big_pkt_en` is 1 and DESC_BYTES (default 2048) when it is 0. The header buffer holds `buf_ctl[15:8]` bytes when `big_pkt_en` is 1 and 0 bytes when it is 0.
- R4: In split layout at offset 0, a frame no longer than the header buffer gets a single header command for the whole frame. The writeback has header length equal to the frame length, split flag 0 and packet length 0.
- R5: In split layout at offset 0, a frame longer than the header buffer with `split_at` in 1..length-1 gets two commands. The header command carries `split_at` bytes. The packet command starts at `split_at` and carries min(length − split_at, packet buffer size) bytes. The writeback has header length `split_at`, split flag 1 and packet length equal to that byte count.
- R6: In split layout with `start_off` in 1..length-1 and a nonzero split point, only a packet command is issued. It starts at `start_off` and carries min(length − start_off, packet buffer size) bytes. The writeback has header length 0 and split flag 0.
- R7: In split layout, a frame longer than the header buffer with `split_at` equal to 0 (no split point found) raises `err` and issues no command.
- R8: `done` pulses for one cycle only after a completion has arrived for every command issued. The two completions may arrive in the same cycle or in either order. A completion for a buffer that was not commanded, or one that arrives while idle, is ignored.
- R9: With `done`, `wb_eop` is 1 exactly when the placed bytes reach the frame length. In that case `frame_pop` pulses and `next_off` is 0; otherwise `next_off` is the cumulative byte count placed.
- R10: `rpt_len` equals the frame length when `crc_strip` is 1 and the frame length plus 4 when it is 0.
- R11: A request is accepted only while `busy` is low. `busy` rises the cycle after an accepted request and falls with `done`. A request made while `busy` is high produces no command and does not change the pending writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Placement request |
| frame_len | input | LEN_W | Frame length in bytes |
| start_off | input | LEN_W | Bytes already placed by earlier descriptors |
| split_at | input | LEN_W | Header/payload split point, 0 if none |
| desc_type | input | 3 | Descriptor layout code |
| big_pkt_en | input | 1 | Large-frame enable |
| buf_ctl | input | 16 | Buffer size control: [7:0] packet KiB, [15:8] header bytes |
| crc_strip | input | 1 | CRC stripped from reported length |
| hdr_cmd_valid | output | 1 | Header-buffer write command (offset 0) |
| hdr_cmd_len | output | LEN_W | Header write byte count |
| pkt_cmd_valid | output | 1 | Packet-buffer write command |
| pkt_cmd_off | output | LEN_W | Frame offset of packet write |
| pkt_cmd_len | output | LEN_W | Packet write byte count |
| hdr_wr_done | input | 1 | Header write completion |
| pkt_wr_done | input | 1 | Packet write completion |
| busy | output | 1 | Writes outstanding |
| err | output | 1 | Request rejected, no command |
| done | output | 1 | Descriptor complete |
| wb_hdr_len | output | LEN_W | Writeback header length |
| wb_split_hdr | output | 1 | Writeback split-header flag |
| wb_pkt_len | output | LEN_W | Writeback packet length |
| wb_eop | output | 1 | End of packet |
| next_off | output | LEN_W | Offset for the next descriptor |
| frame_pop | output | 1 | Remove frame from receive FIFO |
| rpt_len | output | LEN_W+1 | Reported frame length |

## Verification
The bench checks a frame exactly as long as the header buffer, which must go only to the header buffer, against a frame one byte longer, which must split. A design with an off-by-one in that comparison issues the wrong number of commands. A three-descriptor jumbo frame checks the offset chain and that end-of-packet appears only on the last piece; a design that got this wrong would pop the frame early or never. Completions arriving in either order, a completion for a buffer that was never commanded, and a request made while busy each expose a joiner that finishes early or lets a stale request overwrite the pending writeback. Disabling large-frame mode must zero the header buffer and fall back to the fixed packet size.

// File: rtl/rxhs_pkg.sv
package rxhs_pkg;
  typedef enum logic [2:0] {
    LAYOUT_PLAIN  = 3'b000,
    LAYOUT_SINGLE = 3'b001,
    LAYOUT_SPLIT  = 3'b101
  } layout_e;

  // packet buffer capacity in bytes
  function automatic int unsigned pkt_cap(input logic big, input logic [7:0] kib,
                                          input int unsigned fixed_bytes);
    return big ? (int'(kib) << 10) : fixed_bytes;
  endfunction

  // header buffer capacity in bytes
  function automatic int unsigned hdr_cap(input logic big, input logic [7:0] bytes);
    return big ? int'(bytes) : 0;
  endfunction

  function automatic int unsigned umin(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/rxhs_plan.sv
module rxhs_plan
  import rxhs_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int DESC_BYTES = 2048
) (
  input  logic [LEN_W-1:0] frame_len,
  input  logic [LEN_W-1:0] start_off,
  input  logic [LEN_W-1:0] split_at,
  input  logic [2:0]       desc_type,
  input  logic             big_pkt_en,
  input  logic [15:0]      buf_ctl,
  output logic             use_hdr,
  output logic [LEN_W-1:0] hdr_len,
  output logic             use_pkt,
  output logic [LEN_W-1:0] pkt_off,
  output logic [LEN_W-1:0] pkt_len,
  output logic [LEN_W-1:0] wb_hlen,
  output logic             wb_sph,
  output logic [LEN_W-1:0] wb_plen,
  output logic [LEN_W-1:0] fin_off,
  output logic             bad
);
  int unsigned len_i, off_i, spl_i, pcap, hcap, cnt;

  always_comb begin
    len_i = 32'(frame_len);
    off_i = 32'(start_off);
    spl_i = 32'(split_at);
    pcap  = pkt_cap(big_pkt_en, buf_ctl[7:0], DESC_BYTES);
    hcap  = hdr_cap(big_pkt_en, buf_ctl[15:8]);
    cnt   = 0;
    use_hdr = 1'b0; hdr_len = '0; use_pkt = 1'b0; pkt_off = '0; pkt_len = '0;
    wb_hlen = '0; wb_sph = 1'b0; wb_plen = '0; fin_off = '0; bad = 1'b0;
    case (desc_type)
      LAYOUT_PLAIN, LAYOUT_SINGLE: begin
        if (off_i != 0) bad = 1'b1;
        else begin
          use_pkt = 1'b1;
          pkt_len = frame_len;
          wb_plen = frame_len;
          fin_off = frame_len;
        end
      end
      LAYOUT_SPLIT: begin
        if (len_i <= hcap) begin
          if (off_i != 0) bad = 1'b1;
          else begin
            use_hdr = 1'b1;
            hdr_len = frame_len;
            wb_hlen = frame_len;
            fin_off = frame_len;
          end
        end else if (spl_i != 0 && spl_i < len_i) begin
          if (off_i == 0) begin
            cnt     = umin(len_i - spl_i, pcap);
            use_hdr = 1'b1;
            hdr_len = split_at;
            use_pkt = 1'b1;
            pkt_off = split_at;
            pkt_len = LEN_W'(cnt);
            wb_hlen = split_at;
            wb_sph  = 1'b1;
            wb_plen = LEN_W'(cnt);
            fin_off = LEN_W'(spl_i + cnt);
          end else if (off_i < len_i) begin
            cnt     = umin(len_i - off_i, pcap);
            use_pkt = 1'b1;
            pkt_off = start_off;
            pkt_len = LEN_W'(cnt);
            wb_plen = LEN_W'(cnt);
            fin_off = LEN_W'(off_i + cnt);
          end else bad = 1'b1;
        end else bad = 1'b1;
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/rxhs_join.sv
module rxhs_join (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic need_hdr,
  input  logic need_pkt,
  input  logic hdr_done,
  input  logic pkt_done,
  output logic busy,
  output logic fire
);
  logic [1:0] cnt_q, need_q, incr, sum;
  logic       eh_q, ep_q, busy_q, fire_q;

  assign incr = {1'b0, hdr_done & eh_q} + {1'b0, pkt_done & ep_q};
  assign sum  = cnt_q + incr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0; need_q <= '0; eh_q <= 1'b0; ep_q <= 1'b0;
      busy_q <= 1'b0; fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (arm) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        need_q <= {1'b0, need_hdr} + {1'b0, need_pkt};
        eh_q   <= need_hdr;
        ep_q   <= need_pkt;
      end else if (busy_q) begin
        if (sum >= need_q) begin
          busy_q <= 1'b0;
          fire_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= sum;
        end
      end
    end
  end

  assign busy = busy_q;
  assign fire = fire_q;

  // R8: counter never reaches its target while still waiting
  a_r8_cnt_below_need: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < need_q));
  // R8: completion only ends a wait that was in progress
  a_r8_fire_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> (!busy_q && $past(busy_q)));
  // R11: arming happens only while idle
  a_r11_arm_idle: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> !busy_q);
endmodule

// File: rtl/rxhs_place.sv
module rxhs_place #(
  parameter int LEN_W      = 16,
  parameter int DESC_BYTES = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [LEN_W-1:0] start_off,
  input  logic [LEN_W-1:0] split_at,
  input  logic [2:0]       desc_type,
  input  logic             big_pkt_en,
  input  logic [15:0]      buf_ctl,
  input  logic             crc_strip,
  output logic             hdr_cmd_valid,
  output logic [LEN_W-1:0] hdr_cmd_len,
  output logic             pkt_cmd_valid,
  output logic [LEN_W-1:0] pkt_cmd_off,
  output logic [LEN_W-1:0] pkt_cmd_len,
  input  logic             hdr_wr_done,
  input  logic             pkt_wr_done,
  output logic             busy,
  output logic             err,
  output logic             done,
  output logic [LEN_W-1:0] wb_hdr_len,
  output logic             wb_split_hdr,
  output logic [LEN_W-1:0] wb_pkt_len,
  output logic             wb_eop,
  output logic [LEN_W-1:0] next_off,
  output logic             frame_pop,
  output logic [LEN_W:0]   rpt_len
);
  localparam int RL_W = LEN_W + 1;

  logic             p_use_hdr, p_use_pkt, p_sph, p_bad;
  logic [LEN_W-1:0] p_hdr_len, p_pkt_off, p_pkt_len, p_hlen, p_plen, p_fin;
  logic             accept, arm;

  rxhs_plan #(.LEN_W(LEN_W), .DESC_BYTES(DESC_BYTES)) u_plan (
    .frame_len(frame_len), .start_off(start_off), .split_at(split_at),
    .desc_type(desc_type), .big_pkt_en(big_pkt_en), .buf_ctl(buf_ctl),
    .use_hdr(p_use_hdr), .hdr_len(p_hdr_len), .use_pkt(p_use_pkt),
    .pkt_off(p_pkt_off), .pkt_len(p_pkt_len), .wb_hlen(p_hlen),
    .wb_sph(p_sph), .wb_plen(p_plen), .fin_off(p_fin), .bad(p_bad)
  );

  assign accept = req_valid && !busy;
  assign arm    = accept && !p_bad;

  rxhs_join u_join (
    .clk(clk), .rst_n(rst_n), .arm(arm),
    .need_hdr(p_use_hdr), .need_pkt(p_use_pkt),
    .hdr_done(hdr_wr_done), .pkt_done(pkt_wr_done),
    .busy(busy), .fire(done)
  );

  logic [LEN_W-1:0] len_q, fin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_cmd_valid <= 1'b0; hdr_cmd_len <= '0;
      pkt_cmd_valid <= 1'b0; pkt_cmd_off <= '0; pkt_cmd_len <= '0;
      err <= 1'b0;
      wb_hdr_len <= '0; wb_split_hdr <= 1'b0; wb_pkt_len <= '0;
      len_q <= '0; fin_q <= '0; rpt_len <= '0;
    end else begin
      hdr_cmd_valid <= arm && p_use_hdr;
      pkt_cmd_valid <= arm && p_use_pkt;
      err           <= accept && p_bad;
      if (arm) begin
        hdr_cmd_len  <= p_hdr_len;
        pkt_cmd_off  <= p_pkt_off;
        pkt_cmd_len  <= p_pkt_len;
        wb_hdr_len   <= p_hlen;
        wb_split_hdr <= p_sph;
        wb_pkt_len   <= p_plen;
        len_q        <= frame_len;
        fin_q        <= p_fin;
        rpt_len      <= RL_W'(frame_len) + (crc_strip ? RL_W'(0) : RL_W'(4));
      end
    end
  end

  assign wb_eop    = (fin_q == len_q);
  assign next_off  = wb_eop ? '0 : fin_q;
  assign frame_pop = done && wb_eop;

  // R11: no command follows a cycle in which the block was busy
  a_r11_no_cmd_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!hdr_cmd_valid && !pkt_cmd_valid));
  // R7: a rejected request carries no command and no wait
  a_r7_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!hdr_cmd_valid && !pkt_cmd_valid && !busy));
  // R5: payload write begins where the header write ends
  a_r5_data_follows_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_cmd_valid && pkt_cmd_valid) |-> (pkt_cmd_off == hdr_cmd_len));
  // R6: placement never runs past the frame
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_cmd_valid || pkt_cmd_valid) |-> (fin_q <= len_q));
  // R9: an unfinished frame hands on a nonzero offset
  a_r9_partial_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wb_eop) |-> (next_off != '0));
  // R11: completion and rejection are never reported together
  a_r11_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));
endmodule

// File: tb/sim_rxhs_place.sv
module sim_rxhs_place;
  localparam int CLK_P = 10;
  localparam int LW = 16;

  typedef struct packed {
    logic [15:0] len, off, spl;
    logic [2:0]  dt;
    logic        lpe;
    logic [15:0] bc;
    logic        crcs;
    logic [1:0]  ord;   // 0 same cycle, 1 hdr first, 2 pkt first
    logic        eh;
    logic [15:0] hl;
    logic        ep;
    logic [15:0] po, pl, whl;
    logic        sph;
    logic [15:0] wpl;
    logic        er;
    logic [15:0] nxt;
    logic        eop;
    logic [16:0] rl;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    // R2 plain layout
    '{16'd300, 16'd0, 16'd0, 3'd0, 1'b0, 16'h0000, 1'b1, 2'd0, 1'b0, 16'd0, 1'b1, 16'd0, 16'd300, 16'd0, 1'b0, 16'd300, 1'b0, 16'd0, 1'b1, 17'd300},
    // R2 R10 single buffer, CRC kept
    '{16'd1000, 16'd0, 16'd0, 3'd1, 1'b1, 16'h0002, 1'b0, 2'd0, 1'b0, 16'd0, 1'b1, 16'd0, 16'd1000, 16'd0, 1'b0, 16'd1000, 1'b0, 16'd0, 1'b1, 17'd1004},
    // R4 fits header
    '{16'd100, 16'd0, 16'd42, 3'd5, 1'b1, 16'h8001, 1'b1, 2'd0, 1'b1, 16'd100, 1'b0, 16'd0, 16'd0, 16'd100, 1'b0, 16'd0, 1'b0, 16'd0, 1'b1, 17'd100},
    // R5 split, pkt completion first
    '{16'd1500, 16'd0, 16'd54, 3'd5, 1'b1, 16'h8002, 1'b1, 2'd2, 1'b1, 16'd54, 1'b1, 16'd54, 16'd1446, 16'd54, 1'b1, 16'd1446, 1'b0, 16'd0, 1'b1, 17'd1500},
    // R5 R9 jumbo first piece, hdr completion first
    '{16'd3000, 16'd0, 16'd54, 3'd5, 1'b1, 16'h8001, 1'b1, 2'd1, 1'b1, 16'd54, 1'b1, 16'd54, 16'd1024, 16'd54, 1'b1, 16'd1024, 1'b0, 16'd1078, 1'b0, 17'd3000},
    // R6 continuation
    '{16'd3000, 16'd1078, 16'd54, 3'd5, 1'b1, 16'h8001, 1'b1, 2'd0, 1'b0, 16'd0, 1'b1, 16'd1078, 16'd1024, 16'd0, 1'b0, 16'd1024, 1'b0, 16'd2102, 1'b0, 17'd3000},
    // R6 R9 R10 last piece
    '{16'd3000, 16'd2102, 16'd54, 3'd5, 1'b1, 16'h8001, 1'b0, 2'd0, 1'b0, 16'd0, 1'b1, 16'd2102, 16'd898, 16'd0, 1'b0, 16'd898, 1'b0, 16'd0, 1'b1, 17'd3004},
    // R7 no split point
    '{16'd100, 16'd0, 16'd0, 3'd5, 1'b0, 16'h0000, 1'b1, 2'd0, 1'b0, 16'd0, 1'b0, 16'd0, 16'd0, 16'd0, 1'b0, 16'd0, 1'b1, 16'd0, 1'b0, 17'd0},
    // R3 large-frame off: no header room, fixed packet size
    '{16'd1500, 16'd0, 16'd54, 3'd5, 1'b0, 16'h8001, 1'b1, 2'd0, 1'b1, 16'd54, 1'b1, 16'd54, 16'd1446, 16'd54, 1'b1, 16'd1446, 1'b0, 16'd0, 1'b1, 17'd1500},
    // R1 unknown layout code
    '{16'd100, 16'd0, 16'd0, 3'd2, 1'b1, 16'h8001, 1'b1, 2'd0, 1'b0, 16'd0, 1'b0, 16'd0, 16'd0, 16'd0, 1'b0, 16'd0, 1'b1, 16'd0, 1'b0, 17'd0},
    // R1 plain layout with nonzero offset
    '{16'd300, 16'd5, 16'd0, 3'd0, 1'b0, 16'h0000, 1'b1, 2'd0, 1'b0, 16'd0, 1'b0, 16'd0, 16'd0, 16'd0, 1'b0, 16'd0, 1'b1, 16'd0, 1'b0, 17'd0},
    // R4 exactly header size
    '{16'd128, 16'd0, 16'd60, 3'd5, 1'b1, 16'h8001, 1'b1, 2'd0, 1'b1, 16'd128, 1'b0, 16'd0, 16'd0, 16'd128, 1'b0, 16'd0, 1'b0, 16'd0, 1'b1, 17'd128},
    // R5 one byte over header size
    '{16'd129, 16'd0, 16'd60, 3'd5, 1'b1, 16'h8001, 1'b1, 2'd0, 1'b1, 16'd60, 1'b1, 16'd60, 16'd69, 16'd60, 1'b1, 16'd69, 1'b0, 16'd0, 1'b1, 17'd129}
  };

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [LW-1:0] frame_len = '0, start_off = '0, split_at = '0;
  logic [2:0] desc_type = '0;
  logic big_pkt_en = 1'b0, crc_strip = 1'b1;
  logic [15:0] buf_ctl = '0;
  logic hdr_wr_done = 1'b0, pkt_wr_done = 1'b0;
  logic hdr_cmd_valid, pkt_cmd_valid, busy, err, done, wb_split_hdr, wb_eop, frame_pop;
  logic [LW-1:0] hdr_cmd_len, pkt_cmd_off, pkt_cmd_len, wb_hdr_len, wb_pkt_len, next_off;
  logic [LW:0] rpt_len;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  rxhs_place u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    frame_len = v.len; start_off = v.off; split_at = v.spl; desc_type = v.dt;
    big_pkt_en = v.lpe; buf_ctl = v.bc; crc_strip = v.crcs;
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    drive(v); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1/R7 err", err, v.er);
    chk("R11 busy after accept", busy, !v.er);
    chk("R4/R5 hdr cmd valid", hdr_cmd_valid, v.eh);
    chk("R2/R6 pkt cmd valid", pkt_cmd_valid, v.ep);
    if (v.eh) chk("R4/R5 hdr cmd len", hdr_cmd_len, v.hl);
    if (v.ep) begin
      chk("R3/R5/R6 pkt cmd off", pkt_cmd_off, v.po);
      chk("R3/R5/R6 pkt cmd len", pkt_cmd_len, v.pl);
    end
    if (v.er) return;
    if (v.ord == 2'd0 || !(v.eh && v.ep)) begin
      hdr_wr_done = v.eh; pkt_wr_done = v.ep;
      @(negedge clk);
      hdr_wr_done = 1'b0; pkt_wr_done = 1'b0;
    end else begin
      if (v.ord == 2'd1) hdr_wr_done = 1'b1; else pkt_wr_done = 1'b1;
      @(negedge clk);
      hdr_wr_done = 1'b0; pkt_wr_done = 1'b0;
      chk("R8 no done after one of two", done, 0);
      chk("R8 still busy", busy, 1);
      if (v.ord == 2'd1) pkt_wr_done = 1'b1; else hdr_wr_done = 1'b1;
      @(negedge clk);
      hdr_wr_done = 1'b0; pkt_wr_done = 1'b0;
    end
    chk("R8 done", done, 1);
    chk("R11 busy clears", busy, 0);
    chk("R2/R4/R5 wb hdr len", wb_hdr_len, v.whl);
    chk("R5 wb split flag", wb_split_hdr, v.sph);
    chk("R2/R5/R6 wb pkt len", wb_pkt_len, v.wpl);
    chk("R9 eop", wb_eop, v.eop);
    chk("R9 pop", frame_pop, v.eop);
    chk("R9 next off", next_off, v.nxt);
    chk("R10 rpt len", rpt_len, v.rl);
    @(negedge clk);
    chk("R8 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    chk("R11 reset busy", busy, 0);
    chk("R11 reset done", done, 0);
    chk("R1 reset err", err, 0);
    chk("R11 reset cmds", hdr_cmd_valid | pkt_cmd_valid, 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R8: stray completion while idle has no effect
    @(negedge clk);
    pkt_wr_done = 1'b1; hdr_wr_done = 1'b1;
    @(negedge clk);
    pkt_wr_done = 1'b0; hdr_wr_done = 1'b0;
    chk("R8 idle completion ignored done", done, 0);
    chk("R8 idle completion ignored busy", busy, 0);

    // R8: completion for uncommanded buffer is ignored
    drive(VEC[0]); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; hdr_wr_done = 1'b1;
    @(negedge clk);
    hdr_wr_done = 1'b0;
    chk("R8 wrong-buffer completion done", done, 0);
    chk("R8 wrong-buffer completion busy", busy, 1);
    pkt_wr_done = 1'b1;
    @(negedge clk);
    pkt_wr_done = 1'b0;
    chk("R8 right completion done", done, 1);
    @(negedge clk);

    // R11: request while busy is dropped
    drive(VEC[3]); req_valid = 1'b1;
    @(negedge clk);
    drive(VEC[0]);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 no cmd while busy", hdr_cmd_valid | pkt_cmd_valid, 0);
    chk("R11 busy held", busy, 1);
    hdr_wr_done = 1'b1; pkt_wr_done = 1'b1;
    @(negedge clk);
    hdr_wr_done = 1'b0; pkt_wr_done = 1'b0;
    chk("R11 done after busy", done, 1);
    chk("R11 writeback kept hdr len", wb_hdr_len, 54);
    chk("R11 writeback kept pkt len", wb_pkt_len, 1446);
    @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule